// File: doc/BRIEF.md
# Key-Sensing Controller Host Command Decoder

This block is the host-facing command interpreter of a matrix key-sensing controller. Command bytes arrive one per cycle on a valid/data stream from the serial receiver. The block decodes each byte, reads the addressed key's values from a register-file port that the acquisition side supplies, and plays out a reply as a byte stream that waits on a ready signal. A byte that arrives while a reply is still going out is held and decoded once the reply is finished.

Two commands are destructive: single-key recalibration and sleep. Each one needs its byte to arrive twice in a row, with no other command in between, inside a confirmation window timed by a prescaled tick counter. When confirmed, the block sends an acknowledge byte and then raises a one-cycle request toward the scan engine. A diagnostic opcode returns the bitwise inverse of the command decoded before it, including rejected bytes, and clears the error flag that rejected bytes set.

Top module: `keycmd_decoder`

## Requirements
- R1: After reset, tx_valid, comm_err, recal_req and sleep_req are 0. The remembered previous command is 0x00.
- R2: Byte 0x0F replies with one byte, the bitwise inverse of the command decoded before it. Two 0x0F in a row give 0xF0, and a 0x0F first after reset gives 0xFF.
- R3: A byte outside the accepted set sets comm_err and sends no reply. This covers a key field of 48 or more in a 0x40/0x80/0xC0 group opcode, and any byte with bits 7:6 = 00 other than 0x0F and 0x16. A following 0x0F still replies with the inverse of that byte and clears comm_err.
- R4: Opcode 0x40|k (k = bits 5:0, k < 48) drives key_idx = k and replies with 5 bytes in this order: signal low byte, signal high byte, reference low byte, reference high byte, integrator. No check byte follows.
- R5: Opcode 0x80|k (k < 48) replies with a status byte whose bits 7:5 read 1. Bits 4:0 copy key_status[4:0] in this order: enabled, in detect, signal below low limit, calibrating, calibration failed five times. A check byte follows the status byte.
- R6: The check byte is CRC-8 with polynomial x^8+x^5+x^4+1, processed LSB first. It starts from 0x00, folds in the command byte first and then the status byte.
- R7: Opcode 0xC0|k (k < 48) received twice in a row inside the window replies with ~(0xC0|k). After that byte is accepted, recal_req pulses high for exactly one cycle with recal_key = k.
- R8: 0x16 received twice in a row inside the window replies with 0xE9. After that byte is accepted, sleep_req pulses high for one cycle.
- R9: A single 0xC0|k or 0x16, a second byte that differs, a command in between, or a second copy that comes after WINDOW_TICKS ticks of TICK_CYCLES cycles each: none of these gives a reply or a request. The late copy starts a new window.
- R10: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value.
- R11: A command received while a reply is in progress is decoded after the reply's last byte is accepted, and its reply follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Command byte strobe |
| rx_data | input | 8 | Command byte |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Receiver accepts the reply byte |
| key_idx | output | 6 | Key selected on the register-file port |
| key_signal | input | 16 | Signal of the selected key |
| key_ref | input | 16 | Reference of the selected key |
| key_integ | input | 8 | Detect integrator of the selected key |
| key_status | input | 5 | Status flags of the selected key |
| recal_req | output | 1 | One-cycle recalibrate request |
| recal_key | output | 6 | Key to recalibrate |
| sleep_req | output | 1 | One-cycle sleep request |
| comm_err | output | 1 | A rejected command has been seen |

## Verification
The hardest case to reach is the confirmation window closing between the two copies of a destructive byte. The bench builds the design with a tick of 4 cycles and a 10-tick window. It sends a first copy, idles well beyond 40 cycles and then sends the second copy, and it also confirms after a pause that is still inside the window. The queued-command case needs the receiver to stall: tx_ready is held low while a second byte arrives on the very next cycle.

// File: rtl/keycmd_pkg.sv
package keycmd_pkg;
    localparam logic [7:0] OP_LAST_CMD  = 8'h0F;
    localparam logic [7:0] OP_SLEEP     = 8'h16;
    localparam logic [7:0] SLEEP_ACK    = 8'hE9;
    localparam logic [7:0] CRC_POLY_REV = 8'h8C;  // x^8+x^5+x^4+1, bit-reversed
    localparam int         KEY_FIELD_W  = 6;

    typedef enum logic [1:0] {
        RSP_ECHO,
        RSP_DSET,
        RSP_STAT
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_RECAL,
        ACT_SLEEP
    } act_e;
endpackage

// File: rtl/keycmd_crc8_fold.sv
module keycmd_crc8_fold
    import keycmd_pkg::*;
(
    input  logic [7:0] crc_in,
    input  logic [7:0] data,
    output logic [7:0] crc_out
);
    logic [8:0][7:0] stage;

    assign stage[0] = crc_in;

    for (genvar i = 0; i < 8; i++) begin : g_bit
        logic mix;
        assign mix = stage[i][0] ^ data[i];
        assign stage[i+1] = {1'b0, stage[i][7:1]} ^ (mix ? CRC_POLY_REV : 8'h00);
    end

    assign crc_out = stage[8];
endmodule

// File: rtl/keycmd_window.sv
module keycmd_window #(
    parameter int TICK_CYCLES  = 200000,
    parameter int WINDOW_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam int WW = $clog2(WINDOW_TICKS + 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [WW-1:0] win;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (restart) begin
            w_d.pre = '0;
            w_d.win = '0;
        end else if (w_q.pre == PW'(TICK_CYCLES - 1)) begin
            w_d.pre = '0;
            if (w_q.win < WW'(WINDOW_TICKS)) begin
                w_d.win = w_q.win + 1'b1;
            end
        end else begin
            w_d.pre = w_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign expired = (w_q.win == WW'(WINDOW_TICKS));
endmodule

// File: rtl/keycmd_decoder.sv
module keycmd_decoder
    import keycmd_pkg::*;
#(
    parameter int NUM_KEYS     = 48,
    parameter int TICK_CYCLES  = 200000,
    parameter int WINDOW_TICKS = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic [5:0]  key_idx,
    input  logic [15:0] key_signal,
    input  logic [15:0] key_ref,
    input  logic [7:0]  key_integ,
    input  logic [4:0]  key_status,
    output logic        recal_req,
    output logic [5:0]  recal_key,
    output logic        sleep_req,
    output logic        comm_err
);
    localparam int KW = KEY_FIELD_W;

    typedef struct packed {
        logic            busy;
        rsp_kind_e       kind;
        logic [2:0]      idx;
        logic [7:0]      cmd;
        logic [7:0]      echo;
        logic [KW-1:0]   key;
        act_e            act;
        logic            pend;
        logic [7:0]      pend_byte;
        logic [7:0]      last;
        logic            armed;
        logic            err;
        logic            recal;
        logic            sleep;
    } st_t;

    st_t s_d, s_q;

    logic       win_restart;
    logic       win_expired;
    logic [7:0] stat_byte;
    logic [7:0] crc_cmd;
    logic [7:0] crc_stat;
    logic [2:0] last_idx;

    keycmd_window #(
        .TICK_CYCLES (TICK_CYCLES),
        .WINDOW_TICKS(WINDOW_TICKS)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(win_restart),
        .expired(win_expired)
    );

    assign stat_byte = {3'b111, key_status};

    keycmd_crc8_fold u_crc_cmd (
        .crc_in (8'h00),
        .data   (s_q.cmd),
        .crc_out(crc_cmd)
    );

    keycmd_crc8_fold u_crc_stat (
        .crc_in (crc_cmd),
        .data   (stat_byte),
        .crc_out(crc_stat)
    );

    always_comb begin
        case (s_q.kind)
            RSP_DSET: last_idx = 3'd4;
            RSP_STAT: last_idx = 3'd1;
            default:  last_idx = 3'd0;
        endcase
    end

    always_comb begin
        logic [7:0]    b;
        logic [KW-1:0] k;
        logic          key_ok;
        logic          confirm;

        s_d         = s_q;
        s_d.recal   = 1'b0;
        s_d.sleep   = 1'b0;
        win_restart = 1'b0;

        b       = s_q.pend_byte;
        k       = b[KW-1:0];
        key_ok  = (32'(k) < NUM_KEYS);
        confirm = s_q.armed && (s_q.last == b) && !win_expired;

        // reply play-out
        if (s_q.busy && tx_ready) begin
            if (s_q.idx == last_idx) begin
                s_d.busy  = 1'b0;
                s_d.idx   = '0;
                s_d.recal = (s_q.act == ACT_RECAL);
                s_d.sleep = (s_q.act == ACT_SLEEP);
                s_d.act   = ACT_NONE;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end

        // decode one held byte when idle
        if (s_q.pend && !s_q.busy) begin
            s_d.last  = b;
            s_d.armed = 1'b0;
            s_d.cmd   = b;
            s_d.key   = k;
            s_d.idx   = '0;
            if (b == OP_LAST_CMD) begin
                s_d.busy = 1'b1;
                s_d.kind = RSP_ECHO;
                s_d.echo = ~s_q.last;
                s_d.err  = 1'b0;
            end else if (b == OP_SLEEP) begin
                if (confirm) begin
                    s_d.busy = 1'b1;
                    s_d.kind = RSP_ECHO;
                    s_d.echo = SLEEP_ACK;
                    s_d.act  = ACT_SLEEP;
                end else begin
                    s_d.armed   = 1'b1;
                    win_restart = 1'b1;
                end
            end else if (b[7:6] == 2'b00 || !key_ok) begin
                s_d.err = 1'b1;
            end else if (b[7:6] == 2'b01) begin
                s_d.busy = 1'b1;
                s_d.kind = RSP_DSET;
            end else if (b[7:6] == 2'b10) begin
                s_d.busy = 1'b1;
                s_d.kind = RSP_STAT;
            end else if (confirm) begin
                s_d.busy = 1'b1;
                s_d.kind = RSP_ECHO;
                s_d.echo = ~b;
                s_d.act  = ACT_RECAL;
            end else begin
                s_d.armed   = 1'b1;
                win_restart = 1'b1;
            end
        end

        // input holding register
        if (rx_valid) begin
            s_d.pend      = 1'b1;
            s_d.pend_byte = rx_data;
        end else if (s_q.pend && !s_q.busy) begin
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.kind <= RSP_ECHO;
            s_q.act  <= ACT_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (s_q.kind)
            RSP_DSET: begin
                case (s_q.idx)
                    3'd0:    tx_data = key_signal[7:0];
                    3'd1:    tx_data = key_signal[15:8];
                    3'd2:    tx_data = key_ref[7:0];
                    3'd3:    tx_data = key_ref[15:8];
                    default: tx_data = key_integ;
                endcase
            end
            RSP_STAT: tx_data = (s_q.idx == 3'd0) ? stat_byte : crc_stat;
            default:  tx_data = s_q.echo;
        endcase
    end

    assign tx_valid  = s_q.busy;
    assign key_idx   = s_q.key;
    assign recal_req = s_q.recal;
    assign recal_key = s_q.key;
    assign sleep_req = s_q.sleep;
    assign comm_err  = s_q.err;
endmodule

// File: rtl/keycmd_decoder_chk.sv
module keycmd_decoder_chk #(
    parameter int NUM_KEYS = 48
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_ready,
    input logic       recal_req,
    input logic [5:0] recal_key,
    input logic       sleep_req
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_recal_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recal_req |-> $past(tx_valid && tx_ready && (tx_data == ~{2'b11, recal_key})));

    assert_recal_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recal_req |=> !recal_req);

    assert_recal_key_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recal_req |-> (32'(recal_key) < NUM_KEYS));

    assert_sleep_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> $past(tx_valid && tx_ready && (tx_data == 8'hE9)));
endmodule

bind keycmd_decoder keycmd_decoder_chk #(.NUM_KEYS(NUM_KEYS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .recal_req(recal_req),
    .recal_key(recal_key),
    .sleep_req(sleep_req)
);

// File: tb/keycmd_decoder_test.sv
`timescale 1ns/1ps
module keycmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic [5:0]  key_idx;
    logic [15:0] key_signal;
    logic [15:0] key_ref;
    logic [7:0]  key_integ;
    logic [4:0]  key_status;
    logic        recal_req;
    logic [5:0]  recal_key;
    logic        sleep_req;
    logic        comm_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] req_q[$];   // key for recalibrate, 8'h80 for sleep

    always #2.5 clk = ~clk;

    // register-file model
    assign key_signal = 16'h1200 + 16'(key_idx) * 16'd3;
    assign key_ref    = 16'h34F0 + 16'(key_idx) * 16'd5;
    assign key_integ  = 8'(key_idx) + 8'd7;
    assign key_status = key_idx[4:0] ^ 5'h15;

    keycmd_decoder #(
        .NUM_KEYS(48), .TICK_CYCLES(4), .WINDOW_TICKS(10)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .key_idx(key_idx), .key_signal(key_signal), .key_ref(key_ref),
        .key_integ(key_integ), .key_status(key_status),
        .recal_req(recal_req), .recal_key(recal_key),
        .sleep_req(sleep_req), .comm_err(comm_err)
    );

    function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ d[i];
            r = r >> 1;
            if (fb) r = r ^ 8'h8C;
        end
        return r;
    endfunction

    function automatic void check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endfunction

    function automatic void push(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        tag_q.push_back(req);
    endfunction

    function automatic void expect_dset(input int k);
        logic [15:0] s = 16'h1200 + 16'(k) * 16'd3;
        logic [15:0] r = 16'h34F0 + 16'(k) * 16'd5;
        push(s[7:0], "R4"); push(s[15:8], "R4");
        push(r[7:0], "R4"); push(r[15:8], "R4");
        push(8'(k) + 8'd7, "R4");
    endfunction

    function automatic void expect_stat(input int k);
        logic [7:0] cmd = 8'h80 | 8'(k);
        logic [7:0] st  = {3'b111, 5'(k) ^ 5'h15};
        push(st, "R5");
        push(crc_step(crc_step(8'h00, cmd), st), "R6");
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    check("R9", tx_data, 8'hxx);
                end else begin
                    check(tag_q.pop_front(), tx_data, exp_q.pop_front());
                end
            end
            if (recal_req) begin
                if (req_q.size() == 0) check("R9", {2'b00, recal_key}, 8'hxx);
                else check("R7", {2'b00, recal_key}, req_q.pop_front());
            end
            if (sleep_req) begin
                if (req_q.size() == 0) check("R9", 8'h80, 8'hxx);
                else check("R8", 8'h80, req_q.pop_front());
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            if (exp_q.size() == 0 && req_q.size() == 0 && !tx_valid) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {4'b0, tx_valid, comm_err, recal_req, sleep_req}, 8'h00);

        // R2 inverted echo
        push(8'hFF, "R2"); send(8'h0F); drain();
        push(8'hF0, "R2"); send(8'h0F); drain();

        // R4 data sets, both ends of key range
        expect_dset(0);  send(8'h40); drain();
        expect_dset(47); send(8'h6F); drain();

        // R5 / R6 status with check byte
        expect_stat(5);  send(8'h85); drain();
        expect_stat(47); send(8'hAF); drain();

        // R3 key 48 rejected, then echoed and cleared
        send(8'h70); idle(10);
        check("R3", {7'b0, comm_err}, 8'h01);
        push(8'h8F, "R3"); send(8'h0F); drain();
        check("R3", {7'b0, comm_err}, 8'h00);
        send(8'h23); idle(10);
        check("R3", {7'b0, comm_err}, 8'h01);
        push(8'hDC, "R3"); send(8'h0F); drain();
        check("R3", {7'b0, comm_err}, 8'h00);

        // R7 confirmed recalibrate
        push(8'h38, "R7"); req_q.push_back(8'd7);
        send(8'hC7); send(8'hC7); drain();
        // R7 confirm after a pause still inside the window
        push(8'h36, "R7"); req_q.push_back(8'd9);
        send(8'hC9); idle(20); send(8'hC9); drain();

        // R8 confirmed sleep
        push(8'hE9, "R8"); req_q.push_back(8'h80);
        send(8'h16); send(8'h16); drain();

        // R9 intervening command breaks confirmation
        push(8'h3C, "R9"); send(8'hC3); send(8'h0F);
        send(8'hC3); drain();
        // R9 late second copy: window closed, re-arms only
        idle(60); send(8'hC3); idle(10);
        push(8'h3C, "R9"); send(8'h0F); drain();
        // R9 differing second byte
        send(8'hC1); send(8'hC2); idle(10);
        push(8'h3D, "R9"); send(8'h0F); drain();
        // R9 late sleep copy
        send(8'h16); idle(60); send(8'h16); idle(10);
        push(8'hE9, "R9"); send(8'h0F); drain();

        // R10 reply held while receiver stalls
        tx_ready = 1'b0;
        expect_stat(12); send(8'h8C); idle(8);
        check("R10", {7'b0, tx_valid}, 8'h01);
        check("R10", tx_data, exp_q[0]);
        tx_ready = 1'b1; drain();

        // R11 command queued behind a reply
        tx_ready = 1'b0;
        expect_dset(1); push(8'hBE, "R11");
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h41;
        @(negedge clk); rx_data = 8'h0F;
        @(negedge clk); rx_valid = 1'b0;
        idle(6); tx_ready = 1'b1; drain();

        checks++;
        if (exp_q.size() != 0 || req_q.size() != 0) begin
            errors++;
            $display("FAIL R11: got %0d pending expected 0", exp_q.size() + req_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule